// File: doc/BRIEF.md
# Twin-Wave Time-Redundant Multiply-Add Unit

This unit computes `a * b + c` on unsigned operands in a three-stage pipeline and checks its own arithmetic by running every accepted operation through that pipeline twice, on consecutive cycles. The operand register keeps each accepted operand set for two cycles. The first cycle forms the primary wave and the second forms the shadow wave. Each wave carries a one-bit tag down the pipe. When the primary wave leaves the last stage, its result is parked in a buffer. One cycle later the shadow wave arrives, and the two values are compared. A disagreement shows that a transient or intermittent upset hit one of the two passes. The unit only detects such faults. Replay and recovery belong to the surrounding logic.

The operand register is driven by a three-state machine:
- `HOLD_EMPTY`: no wave is issued.
- `HOLD_PRIMARY`: a primary wave is issued.
- `HOLD_SHADOW`: a shadow wave is issued.

It moves between these states as follows:
- *accept*: `HOLD_EMPTY` → `HOLD_PRIMARY`, and also `HOLD_SHADOW` → `HOLD_PRIMARY`.
- *repeat*: `HOLD_PRIMARY` → `HOLD_SHADOW`.
- *drain*: `HOLD_SHADOW` → `HOLD_EMPTY` when nothing is offered.
- *wait*: `HOLD_EMPTY` → `HOLD_EMPTY`.

`in_ready` is low only in `HOLD_PRIMARY`, so the unit can take at most one operation every two cycles.

A fault-injection port lets a test flip one chosen bit in one chosen stage, for waves of one chosen tag only. This confirms that the comparator reacts.

Top module: `twin_wave_mac`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `out_valid` and `out_err` are 0.
- R2: In the cycle after an operation is accepted (rising edge with `in_valid` and `in_ready` both 1), `in_ready` is 0. In every other cycle it is 1.
- R3: The reported result is the unsigned value `in_a * in_b + in_c` of the accepted operand set, 17 bits wide with the default 8-bit operands.
- R4: Each accepted operation produces exactly one `out_valid` pulse. The pulse is seen in the cycle after the fourth rising edge that follows the accepting edge. Operations complete in acceptance order.
- R5: When no fault is injected, `out_err` is 0 whenever `out_valid` is 1.
- R6: `out_err` is only ever 1 together with `out_valid`.
- R7: With `inj_en`=1, a stage is chosen by `inj_stage`: 1 is the product register, 2 is the sum register, 3 is the output register. A wave is chosen by `inj_wave`: 0 is primary, 1 is shadow. Bit `inj_bit` of the chosen stage's value is then inverted for waves of that tag captured there, and the affected operation reports `out_err`=1.
- R8: `out_result` always carries the primary wave's value. A shadow-wave fault therefore leaves the result correct, and a primary-wave fault shows the corrupted value.
- R9: `inj_stage`=0 or `inj_en`=0 causes no flip: the result is correct and `out_err` is 0.
- R10: Operand values presented while `in_ready` is 0 are ignored. The pair of waves always uses the operand set captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| in_a | input | DATA_W | Multiplicand |
| in_b | input | DATA_W | Multiplier |
| in_c | input | DATA_W | Addend |
| inj_en | input | 1 | Enable the fault-injection hook |
| inj_stage | input | 2 | Stage to corrupt: 0 none, 1 product, 2 sum, 3 output |
| inj_wave | input | 1 | Wave tag to corrupt: 0 primary, 1 shadow |
| inj_bit | input | clog2(2*DATA_W+1) | Bit index to invert |
| out_valid | output | 1 | Shadow wave of an operation has completed |
| out_result | output | 2*DATA_W+1 | Primary wave result |
| out_err | output | 1 | Primary and shadow results differ |

## Verification
When `in_valid` is held high, acceptance of a new operand set and completion of an earlier operation fall on the same edge, because the two-cycle issue rhythm lines up with the four-edge latency. A continuous stream with operands that change every cycle provokes this overlap. The reference model is stepped edge by edge. It predicts `in_ready` and the exact `out_valid` cycle, so a missed acceptance, a wrong operand or a shifted completion shows up as a mismatch on that same clock. Fault cases are run on isolated operations, so the expected flag and result belong unambiguously to one operation.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        HOLD_EMPTY   = 2'd0,
        HOLD_PRIMARY = 2'd1,
        HOLD_SHADOW  = 2'd2
    } hold_state_t;

    localparam logic WAVE_PRIMARY = 1'b0;
    localparam logic WAVE_SHADOW  = 1'b1;
    localparam int   PIPE_STAGES  = 3;
endpackage

// File: rtl/tw_issue.sv
module tw_issue
    import tw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] in_c,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] op_c,
    output logic              wave_valid,
    output logic              wave_tag
);
    hold_state_t state, state_nxt;
    logic accept;

    assign accept = in_valid && in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HOLD_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            HOLD_EMPTY:   state_nxt = accept ? HOLD_PRIMARY : HOLD_EMPTY;
            HOLD_PRIMARY: state_nxt = HOLD_SHADOW;
            HOLD_SHADOW:  state_nxt = accept ? HOLD_PRIMARY : HOLD_EMPTY;
            default:      state_nxt = HOLD_EMPTY;
        endcase
    end

    // outputs per state
    always_comb begin
        in_ready   = 1'b1;
        wave_valid = 1'b0;
        wave_tag   = WAVE_PRIMARY;
        unique case (state)
            HOLD_EMPTY: begin
                in_ready   = 1'b1;
                wave_valid = 1'b0;
                wave_tag   = WAVE_PRIMARY;
            end
            HOLD_PRIMARY: begin
                in_ready   = 1'b0;
                wave_valid = 1'b1;
                wave_tag   = WAVE_PRIMARY;
            end
            HOLD_SHADOW: begin
                in_ready   = 1'b1;
                wave_valid = 1'b1;
                wave_tag   = WAVE_SHADOW;
            end
            default: begin
                in_ready   = 1'b1;
                wave_valid = 1'b0;
                wave_tag   = WAVE_PRIMARY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a <= '0;
            op_b <= '0;
            op_c <= '0;
        end else if (accept) begin
            op_a <= in_a;
            op_b <= in_b;
            op_c <= in_c;
        end
    end

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r2_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);
endmodule

// File: rtl/tw_pipe.sv
module tw_pipe
    import tw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wave_valid,
    input  logic                                wave_tag,
    input  logic [DATA_W-1:0]                   op_a,
    input  logic [DATA_W-1:0]                   op_b,
    input  logic [DATA_W-1:0]                   op_c,
    input  logic                                inj_en,
    input  logic [1:0]                          inj_stage,
    input  logic                                inj_wave,
    input  logic [$clog2(2*DATA_W+1)-1:0]       inj_bit,
    output logic                                s3_valid,
    output logic                                s3_tag,
    output logic [2*DATA_W:0]                   s3_res
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int RES_W  = PROD_W + 1;

    logic [PIPE_STAGES:0]   v_chain;
    logic [PIPE_STAGES:0]   t_chain;
    logic [PIPE_STAGES-1:0] hit;
    logic [RES_W-1:0]       flip;

    logic [PROD_W-1:0] s1_prod;
    logic [DATA_W-1:0] s1_add;
    logic [RES_W-1:0]  s2_sum;
    logic [RES_W-1:0]  s3_val;

    assign v_chain[0] = wave_valid;
    assign t_chain[0] = wave_tag;
    assign flip       = RES_W'(1) << inj_bit;

    // valid/tag travel alongside the data; each stage decides its own injection hit
    for (genvar k = 0; k < PIPE_STAGES; k++) begin : g_stage_ctl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_chain[k+1] <= 1'b0;
                t_chain[k+1] <= WAVE_PRIMARY;
            end else begin
                v_chain[k+1] <= v_chain[k];
                t_chain[k+1] <= t_chain[k];
            end
        end
        assign hit[k] = inj_en && (inj_stage == 2'(k + 1)) &&
                        v_chain[k] && (t_chain[k] == inj_wave);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_prod <= '0;
            s1_add  <= '0;
            s2_sum  <= '0;
            s3_val  <= '0;
        end else begin
            s1_prod <= (PROD_W'(op_a) * PROD_W'(op_b)) ^
                       (hit[0] ? flip[PROD_W-1:0] : '0);
            s1_add  <= op_c;
            s2_sum  <= ({1'b0, s1_prod} + RES_W'(s1_add)) ^ (hit[1] ? flip : '0);
            s3_val  <= s2_sum ^ (hit[2] ? flip : '0);
        end
    end

    assign s3_valid = v_chain[PIPE_STAGES];
    assign s3_tag   = t_chain[PIPE_STAGES];
    assign s3_res   = s3_val;

    // R4: a primary wave in the product stage is always trailed by its shadow
    a_r4_shadow_trails: assert property (@(posedge clk) disable iff (!rst_n)
        (v_chain[1] && t_chain[1] == WAVE_PRIMARY) |=>
        (v_chain[1] && t_chain[1] == WAVE_SHADOW));
endmodule

// File: rtl/tw_cmp.sv
module tw_cmp
    import tw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s3_valid,
    input  logic              s3_tag,
    input  logic [2*DATA_W:0] s3_res,
    output logic              out_valid,
    output logic [2*DATA_W:0] out_result,
    output logic              out_err
);
    logic [2*DATA_W:0] prim_buf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   prim_buf <= '0;
        else if (s3_valid && s3_tag == WAVE_PRIMARY)  prim_buf <= s3_res;
    end

    assign out_valid  = s3_valid && (s3_tag == WAVE_SHADOW);
    assign out_result = prim_buf;
    assign out_err    = out_valid && (s3_res != prim_buf);

    // R4: a completing shadow wave was preceded by its primary in the last stage
    a_r4_pair_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_valid && s3_tag == WAVE_SHADOW) |->
        $past(s3_valid && s3_tag == WAVE_PRIMARY));
endmodule

// File: rtl/twin_wave_mac.sv
module twin_wave_mac #(
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [DATA_W-1:0]             in_a,
    input  logic [DATA_W-1:0]             in_b,
    input  logic [DATA_W-1:0]             in_c,
    input  logic                          inj_en,
    input  logic [1:0]                    inj_stage,
    input  logic                          inj_wave,
    input  logic [$clog2(2*DATA_W+1)-1:0] inj_bit,
    output logic                          out_valid,
    output logic [2*DATA_W:0]             out_result,
    output logic                          out_err
);
    logic [DATA_W-1:0] op_a, op_b, op_c;
    logic              wave_valid, wave_tag;
    logic              s3_valid, s3_tag;
    logic [2*DATA_W:0] s3_res;

    tw_issue #(.DATA_W(DATA_W)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .wave_valid(wave_valid), .wave_tag(wave_tag)
    );

    tw_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .wave_valid(wave_valid), .wave_tag(wave_tag),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .inj_en(inj_en), .inj_stage(inj_stage),
        .inj_wave(inj_wave), .inj_bit(inj_bit),
        .s3_valid(s3_valid), .s3_tag(s3_tag), .s3_res(s3_res)
    );

    tw_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .s3_valid(s3_valid), .s3_tag(s3_tag), .s3_res(s3_res),
        .out_valid(out_valid), .out_result(out_result), .out_err(out_err)
    );

    // R5: with the hook idle over a whole operation's flight, no mismatch is flagged
    a_r5_clean_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(inj_en, 1) && !$past(inj_en, 2) &&
         !$past(inj_en, 3) && !$past(inj_en, 4)) |-> !out_err);

    // R6: the error flag never stands alone
    a_r6_err_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);
endmodule

// File: tb/sim_twin_wave_mac.sv
`timescale 1ns/1ps
module sim_twin_wave_mac;
    localparam int W  = 8;
    localparam int RW = 2 * W + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_a = '0, in_b = '0, in_c = '0;
    logic          inj_en = 1'b0;
    logic [1:0]    inj_stage = 2'd0;
    logic          inj_wave = 1'b0;
    logic [4:0]    inj_bit = 5'd0;
    logic          out_valid;
    logic [RW-1:0] out_result;
    logic          out_err;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    bit exp_ready = 1'b1;
    bit finished = 1'b0;

    int           q_due[$];
    logic [RW-1:0] q_res[$];
    bit           q_err[$];

    always #2.5 clk = ~clk;

    twin_wave_mac #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .inj_en(inj_en), .inj_stage(inj_stage),
        .inj_wave(inj_wave), .inj_bit(inj_bit),
        .out_valid(out_valid), .out_result(out_result), .out_err(out_err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    // behavioural expectation of the reported value and flag
    function automatic logic [RW-1:0] ref_value();
        int p, s;
        p = int'(in_a) * int'(in_b);
        if (inj_en && !inj_wave && inj_stage == 2'd1 && inj_bit < 5'd16) p = p ^ (1 << inj_bit);
        s = p + int'(in_c);
        if (inj_en && !inj_wave && (inj_stage == 2'd2 || inj_stage == 2'd3)) s = s ^ (1 << inj_bit);
        return RW'(s);
    endfunction

    function automatic bit ref_err();
        return inj_en && (inj_stage == 2'd2 || inj_stage == 2'd3 ||
                          (inj_stage == 2'd1 && inj_bit < 5'd16));
    endfunction

    // one clock: predict acceptance, advance, then compare at the falling edge
    task automatic cycle();
        bit acc;
        bit want_v;
        acc = in_valid && exp_ready;
        if (acc) begin
            q_due.push_back(edge_n + 5);
            q_res.push_back(ref_value());
            q_err.push_back(ref_err());
        end
        @(posedge clk);
        edge_n++;
        exp_ready = !acc;
        @(negedge clk);
        check(in_ready == exp_ready, "R2 ready", in_ready, exp_ready);
        want_v = (q_due.size() > 0) && (q_due[0] == edge_n);
        check(out_valid == want_v, "R4 out_valid timing", out_valid, want_v);
        if (!out_valid)
            check(out_err == 1'b0, "R6 err without valid", out_err, 0);
        if (want_v) begin
            check(out_result == q_res[0], "R3/R8/R10 result", out_result, q_res[0]);
            check(out_err == q_err[0], "R5/R7/R9 err flag", out_err, q_err[0]);
            void'(q_due.pop_front());
            void'(q_res.pop_front());
            void'(q_err.pop_front());
        end
    endtask

    task automatic drain(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic one_op(input int a, input int b, input int c);
        in_a = W'(a); in_b = W'(b); in_c = W'(c);
        in_valid = 1'b1;
        cycle();
        in_valid = 1'b0;
    endtask

    // isolated operation with the hook held over its whole flight
    task automatic inj_op(input bit en, input int stg, input bit wv, input int bt,
                          input int a, input int b, input int c);
        inj_en = en; inj_stage = 2'(stg); inj_wave = wv; inj_bit = 5'(bt);
        one_op(a, b, c);
        for (int i = 0; i < 6; i++) cycle();
        inj_en = 1'b0; inj_stage = 2'd0; inj_wave = 1'b0; inj_bit = 5'd0;
        drain(2);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(out_err == 1'b0, "R1 out_err", out_err, 0);
        rst_n = 1'b1;
        drain(2);

        // R3/R4: single operation
        one_op(3, 5, 7);
        drain(6);

        // R3: extremes
        one_op(255, 255, 255);
        drain(6);
        one_op(0, 200, 0);
        drain(6);

        // R10/R2: valid held high, operands change every cycle
        for (int i = 0; i < 24; i++) begin
            in_valid = 1'b1;
            in_a = W'(i * 7 + 3); in_b = W'(255 - i * 11); in_c = W'(i * 13);
            cycle();
        end
        drain(7);

        // R2/R4: irregular gaps
        for (int i = 0; i < 30; i++) begin
            in_valid = (i % 3) != 1;
            in_a = W'(i * 29); in_b = W'(i + 1); in_c = W'(100 - i);
            cycle();
        end
        drain(7);

        // R7/R8: every stage, both waves
        for (int s = 1; s <= 3; s++) begin
            inj_op(1'b1, s, 1'b0, 2 + s, 17, 23, 41);
            inj_op(1'b1, s, 1'b1, 4 + s, 99, 12, 200);
        end
        inj_op(1'b1, 3, 1'b0, 16, 255, 255, 255);   // R7 top bit of output
        inj_op(1'b1, 1, 1'b1, 15, 128, 200, 1);     // R7 top bit of product

        // R9: hook enabled but no stage chosen, and hook disabled with a stage chosen
        inj_op(1'b1, 0, 1'b0, 3, 45, 67, 89);
        inj_op(1'b0, 2, 1'b1, 3, 45, 67, 89);

        drain(3);
        check(q_due.size() == 0, "R4 all completed", q_due.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule